// File: doc/BRIEF.md
# Variable-Latency In-Order Integer Pipeline

This block is an in-order integer pipeline with five stages: fetch, decode, operand read, execute and write-back. It runs a short program held in an internal instruction buffer over a small register file. There are four operations: add, subtract, multiply and unsigned divide. Each instruction names a destination register and two source registers.

The execute stage is one unit that is not pipelined, and how long it stays busy depends on the operation. While it is busy, the instruction waiting for it holds in the operand stage and the stages in front of it freeze. A result leaving execute is forwarded straight to a dependent instruction entering execute. A result sitting in write-back passes through the register file's write-through read. The instruction buffer and the register file are filled through two load ports while reset is held. After reset is released the program runs by itself.

The outputs are the whole register file, a retire strobe with the index of the retired instruction, a running cycle count and a done flag. When the program is finished and the pipeline is empty, the count freezes and the done flag rises.

Top module: `pl5_core`

## Requirements
- R1: While reset is high, `retire_o`, `done_o` and `cycles_o` are all zero.
- R2: Writes on the instruction load port (`imem_we_i`) and the register load port (`rf_we_i`) take effect only while reset is high. While the program runs they have no effect on `regs_o` or on the program.
- R3: An instruction word is 11 bits wide. Bits [10:9] hold the operation: 00 add, 01 subtract, 10 multiply, 11 divide. Bits [8:6] hold the destination register, bits [5:3] the first source and bits [2:0] the second source. Results are 16 bits wide: add and subtract wrap, multiply keeps the low 16 bits of the product, and divide is unsigned (first source divided by second).
- R4: Dividing by zero writes 16'hFFFF to the destination.
- R5: Fetch, decode, operand read and write-back each take one cycle. Execute takes 1 cycle for add and subtract, 3 for multiply and 6 for divide. A lone divide therefore finishes with `cycles_o` equal to 10.
- R6: Only one instruction occupies execute at a time. Earlier instructions hold their stages until they can advance, and instructions retire in program order, at most one per cycle.
- R7: A source register that matches the destination of the instruction leaving execute takes that result, not the register file value. The dependent instruction enters execute in the very next cycle.
- R8: The register file is written in the write-back cycle. A source read in that same cycle sees the value being written.
- R9: `retire_o` is high for one cycle, the cycle after an instruction's write-back, and `retire_idx_o` then holds that instruction's buffer index. In that same cycle `regs_o` already shows the new value.
- R10: Cycle 1 is the first cycle after reset. `cycles_o` counts the cycles from cycle 1 up to the last write-back and then holds. `done_o` rises in the cycle after the pipeline drains and stays high. With an empty program, `done_o` is high from cycle 1 and `cycles_o` stays at 0.
- R11: The sequence multiply R2,R0,R1; divide R5,R3,R4; add R2,R5,R2; subtract R5,R2,R6 finishes its last write-back in cycle 15, so `cycles_o` ends at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the load window |
| imem_we_i | input | 1 | Instruction buffer write enable (honoured in reset only) |
| imem_addr_i | input | 4 | Instruction buffer write address |
| imem_data_i | input | 11 | Instruction word to store |
| rf_we_i | input | 1 | Register file load enable (honoured in reset only) |
| rf_addr_i | input | 3 | Register to load |
| rf_data_i | input | 16 | Value to load |
| prog_len_i | input | 5 | Number of instructions in the program |
| regs_o | output | 128 | Register file contents, register i at bits [16i+15:16i] |
| retire_o | output | 1 | One-cycle retire strobe |
| retire_idx_o | output | 4 | Buffer index of the retired instruction |
| cycles_o | output | 32 | Cycles counted since reset, frozen at halt |
| done_o | output | 1 | Program finished and pipeline empty |

## Verification
The reference model computes four cycle numbers for each instruction: when it enters decode, operand read, execute and write-back. Each is the earliest cycle that the previous instruction's occupancy and the execute latency allow. An instruction whose write-back falls in cycle n shows its retire strobe, index and register value at the sample taken just after the n-th rising edge after reset. The count reads min(n, last write-back), and `done_o` is expected from sample last-write-back+1 onward. Outputs are sampled on the falling edge after every rising edge and compared against that schedule. After each program the bench also checks explicitly the final count for fixed cases: the four-instruction sequence, a lone divide and an empty program.

// File: rtl/pl5_pkg.sv
package pl5_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } op_e;

endpackage

// File: rtl/pl5_fetch.sv
module pl5_fetch #(
  parameter int DEPTH = 16,
  parameter int IW    = 11,
  localparam int IAW  = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_we_i,
  input  logic [IAW-1:0] ld_addr_i,
  input  logic [IW-1:0]  ld_data_i,
  input  logic [PW-1:0]  prog_len_i,
  input  logic           take_i,
  output logic           fd_valid_o,
  output logic [IW-1:0]  fd_instr_o,
  output logic [IAW-1:0] fd_idx_o,
  output logic           drained_o
);

  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] pc;
  logic          fetch_en;

  assign drained_o = (pc >= prog_len_i);
  assign fetch_en  = !rst && !drained_o && (!fd_valid_o || take_i);

  // Buffer port: loads in reset only, synchronous read into the fetch register.
  always_ff @(posedge clk) begin
    if (rst && ld_we_i) begin
      mem[ld_addr_i] <= ld_data_i;
    end
    if (fetch_en) begin
      fd_instr_o <= mem[pc[IAW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      fd_valid_o <= 1'b0;
      fd_idx_o   <= '0;
    end else if (fetch_en) begin
      pc         <= pc + 1'b1;
      fd_valid_o <= 1'b1;
      fd_idx_o   <= pc[IAW-1:0];
    end else if (take_i) begin
      fd_valid_o <= 1'b0;
    end
  end

  // R6: a fetched instruction not taken by decode stays put.
  p_fetch_hold_r6 : assert property (@(posedge clk) disable iff (rst)
    (fd_valid_o && !take_i) |=> (fd_valid_o && $stable(fd_instr_o) && $stable(fd_idx_o)));

  // R6: the fetch pointer never runs past the program.
  p_pc_bound_r6 : assert property (@(posedge clk) disable iff (rst)
    (pc <= prog_len_i) || $stable(pc));

endmodule

// File: rtl/pl5_regfile.sv
module pl5_regfile #(
  parameter int NREG  = 8,
  parameter int XLEN  = 16,
  localparam int RIW  = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_we_i,
  input  logic [RIW-1:0]       ld_addr_i,
  input  logic [XLEN-1:0]      ld_data_i,
  input  logic                 wr_en_i,
  input  logic [RIW-1:0]       wr_addr_i,
  input  logic [XLEN-1:0]      wr_data_i,
  input  logic [RIW-1:0]       ra_addr_i,
  output logic [XLEN-1:0]      ra_data_o,
  input  logic [RIW-1:0]       rb_addr_i,
  output logic [XLEN-1:0]      rb_data_o,
  output logic [NREG*XLEN-1:0] flat_o
);

  logic [XLEN-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_we_i) begin
        rf[ld_addr_i] <= ld_data_i;
      end
    end else if (wr_en_i) begin
      rf[wr_addr_i] <= wr_data_i;
    end
  end

  // Write-through reads: a register written this cycle reads as its new value.
  always_comb begin
    ra_data_o = rf[ra_addr_i];
    rb_data_o = rf[rb_addr_i];
    if (wr_en_i && (wr_addr_i == ra_addr_i)) ra_data_o = wr_data_i;
    if (wr_en_i && (wr_addr_i == rb_addr_i)) rb_data_o = wr_data_i;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_o[g*XLEN +: XLEN] = rf[g];
  end

  // R8: a write-back is visible in the register array on the next cycle.
  p_wb_lands_r8 : assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> (rf[$past(wr_addr_i)] == $past(wr_data_i)));

endmodule

// File: rtl/pl5_exec.sv
module pl5_exec import pl5_pkg::*; #(
  parameter int XLEN    = 16,
  parameter int RIW     = 3,
  parameter int IAW     = 4,
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 3,
  parameter int LAT_DIV = 6,
  localparam int LMAX   = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ALU) ? LAT_DIV : LAT_ALU)
                                              : ((LAT_MUL > LAT_ALU) ? LAT_MUL : LAT_ALU),
  localparam int LW     = $clog2(LMAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  op_e             op_i,
  input  logic [RIW-1:0]  rd_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [IAW-1:0]  idx_i,
  output logic            ready_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] res_o,
  output logic [RIW-1:0]  rd_o,
  output logic [IAW-1:0]  idx_o
);

  function automatic logic [LW-1:0] lat_of(input op_e op);
    case (op)
      OP_MUL:  lat_of = LW'(LAT_MUL);
      OP_DIV:  lat_of = LW'(LAT_DIV);
      default: lat_of = LW'(LAT_ALU);
    endcase
  endfunction

  op_e             cur_op;
  logic [XLEN-1:0] opa, opb;
  logic [LW-1:0]   left;

  assign done_o  = busy_o && (left == LW'(1));
  assign ready_o = !busy_o || done_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      left   <= '0;
    end else if (issue_i) begin
      busy_o <= 1'b1;
      left   <= lat_of(op_i);
    end else if (done_o) begin
      busy_o <= 1'b0;
      left   <= '0;
    end else if (busy_o) begin
      left   <= left - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (issue_i) begin
      cur_op <= op_i;
      rd_o   <= rd_i;
      idx_o  <= idx_i;
      opa    <= a_i;
      opb    <= b_i;
    end
  end

  always_comb begin
    case (cur_op)
      OP_ADD:  res_o = opa + opb;
      OP_SUB:  res_o = opa - opb;
      OP_MUL:  res_o = opa * opb;
      default: res_o = (opb == '0) ? '1 : (opa / opb);
    endcase
  end

  // Occupancy counted upward from issue, independently of the countdown.
  logic [LW-1:0] occ;
  always_ff @(posedge clk) begin
    if (rst)          occ <= '0;
    else if (issue_i) occ <= LW'(1);
    else if (busy_o)  occ <= occ + 1'b1;
  end

  // R6: nothing issues into an occupied unit.
  p_issue_free_r6 : assert property (@(posedge clk) disable iff (rst)
    issue_i |-> (!busy_o || done_o));

  // R6: an instruction in flight keeps its identity until it completes.
  p_inflight_hold_r6 : assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> (busy_o && $stable(rd_o) && $stable(idx_o)));

  // R5: completion comes exactly after the opcode's latency.
  p_latency_r5 : assert property (@(posedge clk) disable iff (rst)
    done_o |-> (occ == lat_of(cur_op)));

endmodule

// File: rtl/pl5_core.sv
module pl5_core import pl5_pkg::*; #(
  parameter int NREG       = 8,
  parameter int XLEN       = 16,
  parameter int IMEM_DEPTH = 16,
  parameter int CW         = 32,
  parameter int LAT_ALU    = 1,
  parameter int LAT_MUL    = 3,
  parameter int LAT_DIV    = 6,
  localparam int RIW       = $clog2(NREG),
  localparam int IW        = 2 + 3 * RIW,
  localparam int IAW       = $clog2(IMEM_DEPTH),
  localparam int PW        = $clog2(IMEM_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 imem_we_i,
  input  logic [IAW-1:0]       imem_addr_i,
  input  logic [IW-1:0]        imem_data_i,
  input  logic                 rf_we_i,
  input  logic [RIW-1:0]       rf_addr_i,
  input  logic [XLEN-1:0]      rf_data_i,
  input  logic [PW-1:0]        prog_len_i,
  output logic [NREG*XLEN-1:0] regs_o,
  output logic                 retire_o,
  output logic [IAW-1:0]       retire_idx_o,
  output logic [CW-1:0]        cycles_o,
  output logic                 done_o
);

  // Fetch stage.
  logic           fd_valid, fd_take, drained;
  logic [IW-1:0]  fd_instr;
  logic [IAW-1:0] fd_idx;

  pl5_fetch #(.DEPTH(IMEM_DEPTH), .IW(IW)) u_fetch (
    .clk(clk), .rst(rst),
    .ld_we_i(imem_we_i), .ld_addr_i(imem_addr_i), .ld_data_i(imem_data_i),
    .prog_len_i(prog_len_i), .take_i(fd_take),
    .fd_valid_o(fd_valid), .fd_instr_o(fd_instr), .fd_idx_o(fd_idx),
    .drained_o(drained)
  );

  // Decode stage: split the word into fields for the operand stage.
  logic           do_valid, issue;
  op_e            do_op;
  logic [RIW-1:0] do_rd, do_rs1, do_rs2;
  logic [IAW-1:0] do_idx;

  assign fd_take = !do_valid || issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      do_valid <= 1'b0;
    end else if (fd_take) begin
      do_valid <= fd_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (fd_take && fd_valid) begin
      do_op  <= op_e'(fd_instr[IW-1 -: 2]);
      do_rd  <= fd_instr[3*RIW-1 -: RIW];
      do_rs1 <= fd_instr[2*RIW-1 -: RIW];
      do_rs2 <= fd_instr[RIW-1:0];
      do_idx <= fd_idx;
    end
  end

  // Operand stage: register reads, forwarding from the instruction leaving execute.
  logic            ex_ready, ex_busy, ex_done;
  logic [XLEN-1:0] ex_res;
  logic [RIW-1:0]  ex_rd;
  logic [IAW-1:0]  ex_idx;
  logic            wb_valid;
  logic [RIW-1:0]  wb_rd;
  logic [XLEN-1:0] wb_val;
  logic [IAW-1:0]  wb_idx;
  logic [XLEN-1:0] rf_a, rf_b, op_a, op_b;

  pl5_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ld_we_i(rf_we_i), .ld_addr_i(rf_addr_i), .ld_data_i(rf_data_i),
    .wr_en_i(wb_valid), .wr_addr_i(wb_rd), .wr_data_i(wb_val),
    .ra_addr_i(do_rs1), .ra_data_o(rf_a),
    .rb_addr_i(do_rs2), .rb_data_o(rf_b),
    .flat_o(regs_o)
  );

  always_comb begin
    op_a = rf_a;
    op_b = rf_b;
    if (ex_done && (ex_rd == do_rs1)) op_a = ex_res;
    if (ex_done && (ex_rd == do_rs2)) op_b = ex_res;
  end

  assign issue = do_valid && ex_ready;

  pl5_exec #(
    .XLEN(XLEN), .RIW(RIW), .IAW(IAW),
    .LAT_ALU(LAT_ALU), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
  ) u_exec (
    .clk(clk), .rst(rst),
    .issue_i(issue), .op_i(do_op), .rd_i(do_rd),
    .a_i(op_a), .b_i(op_b), .idx_i(do_idx),
    .ready_o(ex_ready), .busy_o(ex_busy), .done_o(ex_done),
    .res_o(ex_res), .rd_o(ex_rd), .idx_o(ex_idx)
  );

  // Write-back stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= ex_done;
    end
  end

  always_ff @(posedge clk) begin
    if (ex_done) begin
      wb_rd  <= ex_rd;
      wb_val <= ex_res;
      wb_idx <= ex_idx;
    end
  end

  // Retire reporting, cycle count and halt.
  logic halt;
  assign halt = drained && !fd_valid && !do_valid && !ex_busy && !wb_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      retire_o     <= 1'b0;
      retire_idx_o <= '0;
      cycles_o     <= '0;
      done_o       <= 1'b0;
    end else begin
      retire_o <= wb_valid;
      if (wb_valid) retire_idx_o <= wb_idx;
      if (!halt) cycles_o <= cycles_o + 1'b1;
      done_o <= halt;
    end
  end

  // R6: an operand-stage instruction blocked by execute keeps its contents.
  p_operand_hold_r6 : assert property (@(posedge clk) disable iff (rst)
    (do_valid && !issue) |=> (do_valid && $stable(do_idx) && $stable(do_rd)));

  // R10: once done, the flag stays high and the count is frozen.
  p_done_frozen_r10 : assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && $stable(cycles_o)));

  // R10: while work remains, the count advances by one per cycle.
  p_count_step_r10 : assert property (@(posedge clk) disable iff (rst)
    (!halt && !done_o) |=> (cycles_o == $past(cycles_o) + 1'b1));

  // R9: nothing retires after the done flag.
  p_quiet_after_done_r9 : assert property (@(posedge clk) disable iff (rst)
    done_o |-> !retire_o);

  // R7: write-back data always comes from a completion in the previous cycle.
  p_wb_from_exec_r7 : assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(ex_done));

endmodule

// File: tb/pl5_core_test.sv
module pl5_core_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         imem_we_i = 1'b0;
  logic [3:0]   imem_addr_i = '0;
  logic [10:0]  imem_data_i = '0;
  logic         rf_we_i = 1'b0;
  logic [2:0]   rf_addr_i = '0;
  logic [15:0]  rf_data_i = '0;
  logic [4:0]   prog_len_i = '0;
  logic [127:0] regs_o;
  logic         retire_o;
  logic [3:0]   retire_idx_o;
  logic [31:0]  cycles_o;
  logic         done_o;

  pl5_core uut (
    .clk(clk), .rst(rst),
    .imem_we_i(imem_we_i), .imem_addr_i(imem_addr_i), .imem_data_i(imem_data_i),
    .rf_we_i(rf_we_i), .rf_addr_i(rf_addr_i), .rf_data_i(rf_data_i),
    .prog_len_i(prog_len_i),
    .regs_o(regs_o), .retire_o(retire_o), .retire_idx_o(retire_idx_o),
    .cycles_o(cycles_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R10 watchdog expired: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // Program under test (R3 encoding: op[10:9], rd[8:6], rs1[5:3], rs2[2:0]).
  int          np;
  int          p_op[16], p_rd[16], p_rs1[16], p_rs2[16];
  logic [15:0] init_r[8];
  logic [15:0] mreg[8];
  logic [15:0] res[16];
  int          w_at[16];
  int          last_w;

  function automatic int lat(input int op);
    return (op == 2) ? 3 : (op == 3) ? 6 : 1;
  endfunction

  function automatic logic [15:0] alu(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return (b == 16'd0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  task automatic add_ins(input int op, input int rd, input int s1, input int s2);
    p_op[np] = op; p_rd[np] = rd; p_rs1[np] = s1; p_rs2[np] = s2;
    np++;
  endtask

  // Behavioural schedule: earliest entry into decode, operand read, execute.
  task automatic build_model();
    int a_prev, b_prev, e_prev, l_prev;
    logic [15:0] seq[8];
    for (int r = 0; r < 8; r++) seq[r] = init_r[r];
    a_prev = 1; b_prev = 2; e_prev = 3; l_prev = 0;
    last_w = 0;
    for (int k = 0; k < np; k++) begin
      int a, b, e;
      a = (k == 0) ? 2 : ((a_prev + 1 > b_prev) ? a_prev + 1 : b_prev);
      b = (k == 0) ? 3 : ((a + 1 > e_prev) ? a + 1 : e_prev);
      e = (k == 0) ? 4 : ((b + 1 > e_prev + l_prev) ? b + 1 : e_prev + l_prev);
      w_at[k] = e + lat(p_op[k]);
      res[k] = alu(p_op[k], seq[p_rs1[k]], seq[p_rs2[k]]);
      seq[p_rd[k]] = res[k];
      a_prev = a; b_prev = b; e_prev = e; l_prev = lat(p_op[k]);
      last_w = w_at[k];
    end
  endtask

  task automatic run_prog(input string tag, input bit noise);
    build_model();
    rst = 1'b1;
    prog_len_i = 5'(np);
    for (int k = 0; k < np; k++) begin
      @(negedge clk);
      imem_we_i = 1'b1; imem_addr_i = 4'(k);
      imem_data_i = {2'(p_op[k]), 3'(p_rd[k]), 3'(p_rs1[k]), 3'(p_rs2[k])};
    end
    @(negedge clk); imem_we_i = 1'b0;
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      rf_we_i = 1'b1; rf_addr_i = 3'(r); rf_data_i = init_r[r];
    end
    @(negedge clk); rf_we_i = 1'b0;
    @(negedge clk);
    chk("R1", "retire in reset", 32'(retire_o), 32'd0);
    chk("R1", "cycles in reset", cycles_o, 32'd0);
    chk("R1", "done in reset", 32'(done_o), 32'd0);
    for (int r = 0; r < 8; r++) mreg[r] = init_r[r];
    rst = 1'b0;
    for (int n = 1; n <= last_w + 3; n++) begin
      bit exp_ret;
      int exp_idx;
      // Loads driven during the run must be ignored (R2).
      if (noise && n >= 2 && n <= 6) begin
        rf_we_i = 1'b1; rf_addr_i = 3'd7; rf_data_i = 16'hBEEF;
        imem_we_i = 1'b1; imem_addr_i = 4'(np); imem_data_i = 11'h7FF;
      end else begin
        rf_we_i = 1'b0; imem_we_i = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      exp_ret = 1'b0; exp_idx = 0;
      for (int k = 0; k < np; k++) begin
        if (w_at[k] == n) begin
          exp_ret = 1'b1; exp_idx = k; mreg[p_rd[k]] = res[k];
        end
      end
      chk("R9", {tag, " retire strobe"}, 32'(retire_o), 32'(exp_ret));
      if (exp_ret) chk("R6", {tag, " retire index"}, 32'(retire_idx_o), 32'(exp_idx));
      for (int r = 0; r < 8; r++)
        chk(noise ? "R2" : "R8", $sformatf("%s reg %0d", tag, r),
            32'(regs_o[r*16 +: 16]), 32'(mreg[r]));
      chk("R10", {tag, " cycle count"}, cycles_o, 32'((n < last_w) ? n : last_w));
      chk("R10", {tag, " done flag"}, 32'(done_o), 32'(n >= last_w + 1));
    end
    rf_we_i = 1'b0; imem_we_i = 1'b0;
  endtask

  task automatic set_regs(input logic [15:0] v0, v1, v2, v3, v4, v5, v6, v7);
    init_r[0] = v0; init_r[1] = v1; init_r[2] = v2; init_r[3] = v3;
    init_r[4] = v4; init_r[5] = v5; init_r[6] = v6; init_r[7] = v7;
  endtask

  initial begin
    // R11: the four-instruction sequence with a multiply, a divide and two dependents.
    np = 0;
    set_regs(16'd7, 16'd9, 16'd0, 16'd100, 16'd7, 16'd0, 16'd5, 16'd0);
    add_ins(2, 2, 0, 1); add_ins(3, 5, 3, 4); add_ins(0, 2, 5, 2); add_ins(1, 5, 2, 6);
    run_prog("seq", 1'b0);
    chk("R11", "final cycle count", cycles_o, 32'd15);
    chk("R7", "forwarded add result", 32'(regs_o[2*16 +: 16]), 32'd77);
    chk("R7", "forwarded sub result", 32'(regs_o[5*16 +: 16]), 32'd72);

    // R3 wrap cases with load-port noise during the run (R2).
    np = 0;
    set_regs(16'd4, 16'd0, 16'hFFFF, 16'd2, 16'd0, 16'd3, 16'd5, 16'd0);
    add_ins(0, 1, 2, 3); add_ins(1, 4, 5, 6); add_ins(2, 7, 2, 2); add_ins(0, 0, 0, 0);
    run_prog("wrap", 1'b1);
    chk("R3", "add wraps", 32'(regs_o[1*16 +: 16]), 32'h0001);
    chk("R3", "sub wraps", 32'(regs_o[4*16 +: 16]), 32'hFFFE);
    chk("R2", "load during run ignored", 32'(regs_o[7*16 +: 16]), 32'h0001);

    // R4 and R7: divide by zero feeding a chain of back-to-back dependents.
    np = 0;
    set_regs(16'd0, 16'd0, 16'd40, 16'd0, 16'd0, 16'd0, 16'd0, 16'd3);
    add_ins(3, 1, 2, 0); add_ins(0, 3, 1, 1); add_ins(1, 4, 3, 1);
    add_ins(2, 5, 4, 4); add_ins(3, 6, 5, 7); add_ins(0, 2, 6, 5);
    run_prog("chain", 1'b0);
    chk("R4", "divide by zero", 32'(regs_o[1*16 +: 16]), 32'hFFFF);
    chk("R7", "chain tail", 32'(regs_o[2*16 +: 16]), 32'd1);

    // R8: a source produced two instructions earlier arrives through write-back.
    np = 0;
    set_regs(16'd5, 16'd0, 16'd0, 16'd9, 16'd0, 16'd0, 16'd0, 16'd0);
    add_ins(0, 1, 0, 0); add_ins(1, 2, 3, 3); add_ins(0, 4, 1, 2);
    run_prog("bypass", 1'b0);
    chk("R8", "write-through read", 32'(regs_o[4*16 +: 16]), 32'd10);

    // R5: a lone divide.
    np = 0;
    set_regs(16'd0, 16'd0, 16'd50, 16'd7, 16'd0, 16'd0, 16'd0, 16'd0);
    add_ins(3, 1, 2, 3);
    run_prog("lone", 1'b0);
    chk("R5", "lone divide cycles", cycles_o, 32'd10);
    chk("R3", "unsigned divide", 32'(regs_o[1*16 +: 16]), 32'd7);

    // R10: empty program.
    np = 0;
    set_regs(16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'd6, 16'd7, 16'd8);
    run_prog("empty", 1'b0);
    chk("R10", "empty program count", cycles_o, 32'd0);
    chk("R10", "empty program done", 32'(done_o), 32'd1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule